// File: doc/BRIEF.md
# SMT Priority Issue Slot Allocator

This block hands out the functional-unit issue slots of one machine cycle among three hardware threads that share a single datapath. Every thread keeps an in-order instruction queue. The allocator looks at the oldest few entries of each queue. For each entry it sees the instruction class and a flag saying that the operands are ready. The slots are typed: two ALU slots, one memory slot shared by loads and stores, and one branch slot.

Threads are served in a fixed priority order. Thread 0 takes slots first. Thread 1 then takes what is left, and thread 2 takes the remainder after that. Inside one thread the scan starts at the queue head and moves toward younger entries. It ends at the first entry that is not ready or that has no free slot of its class. No younger instruction can therefore pass an older one that was held back. Several instructions from one thread can issue together in the same cycle.

For each slot the result is a valid bit, a thread number and a queue position. For each thread it is a pop count, which the queue uses to drop the issued entries. All outputs are registered and appear one clock after the inputs they were computed from.

Top module: `smt_issue_alloc`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises with no ready entries, every slot valid bit and every pop count is zero.
- R2: Slot 0 and slot 1 carry only ALU instructions, slot 2 only loads or stores, and slot 3 only branches. Class codes are 2'b00 ALU, 2'b01 load, 2'b10 store and 2'b11 branch.
- R3: Thread 0 is served before thread 1, and thread 1 before thread 2. A lower-priority thread gets only the slots that the higher ones left free.
- R4: A thread's scan stops at its first entry whose ready flag is low. No younger entry of that thread is granted in that cycle.
- R5: A thread's scan also stops at its first ready entry whose class has no free slot left, even when a later entry could have fitted.
- R6: A load and a store compete for the same single memory slot. At most one memory instruction issues per cycle across all threads.
- R7: A thread's pop count equals the number of slots granted to it, and the granted entries are its oldest ones: positions 0 to pop-1.
- R8: One thread can issue up to four instructions in a cycle, one per slot, when its classes and ready flags allow it.
- R9: ALU grants fill slot 0 before slot 1, in thread-priority order and then in queue order.
- R10: Outputs are registered. They change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cls_i | input | 24 | Class of entry p of thread t at bits [(t*4+p)*2 +: 2], where p=0 is the head |
| rdy_i | input | 12 | Ready flag of entry p of thread t at bit t*4+p |
| slot_vld_o | output | 4 | Slot k holds a grant (0,1 ALU; 2 memory; 3 branch) |
| slot_tid_o | output | 8 | Thread of the grant in slot k at bits [k*2 +: 2] |
| slot_pos_o | output | 8 | Queue position of the grant in slot k at bits [k*2 +: 2] |
| pop_cnt_o | output | 9 | Pop count of thread t at bits [t*3 +: 3] |

## Verification
The bench uses the default parameters: three threads, a scan depth of four, and two ALU slots, one memory slot and one branch slot. With these values a single thread can fill every slot type in one cycle. The second ALU slot and the single memory slot can also be exhausted, so the scan stops on a missing resource and not only on a low ready flag. The directed cases cover three situations: the top thread stalled at its head, load and store colliding on the memory slot, and leftover slots passing down to the lowest thread. A final case confirms the one-cycle register latency.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } instr_cls_e;

  typedef enum logic [1:0] {
    UNIT_ALU = 2'd0,
    UNIT_MEM = 2'd1,
    UNIT_BR  = 2'd2
  } unit_e;

  function automatic unit_e unit_of(input logic [1:0] cls);
    case (instr_cls_e'(cls))
      CLS_ALU:              return UNIT_ALU;
      CLS_LOAD, CLS_STORE:  return UNIT_MEM;
      default:              return UNIT_BR;
    endcase
  endfunction

endpackage

// File: rtl/thread_scan.sv
module thread_scan
  import smt_issue_pkg::*;
#(
  parameter int SCAN_DEPTH = 4,
  parameter int FW         = 2,
  parameter int CW         = 3
) (
  input  logic [SCAN_DEPTH*2-1:0] cls_i,
  input  logic [SCAN_DEPTH-1:0]   rdy_i,
  input  logic [FW-1:0]           alu_free_i,
  input  logic [FW-1:0]           mem_free_i,
  input  logic [FW-1:0]           br_free_i,
  output logic [FW-1:0]           alu_free_o,
  output logic [FW-1:0]           mem_free_o,
  output logic [FW-1:0]           br_free_o,
  output logic [SCAN_DEPTH-1:0]   grant_o,
  output logic [CW-1:0]           pop_o
);

  logic  stop;
  logic  fit;
  unit_e unit;

  // in-order walk from the head; first miss blocks all younger entries
  always_comb begin
    alu_free_o = alu_free_i;
    mem_free_o = mem_free_i;
    br_free_o  = br_free_i;
    grant_o    = '0;
    pop_o      = '0;
    stop       = 1'b0;
    fit        = 1'b0;
    unit       = UNIT_ALU;
    for (int p = 0; p < SCAN_DEPTH; p++) begin
      unit = unit_of(cls_i[p*2 +: 2]);
      case (unit)
        UNIT_ALU: fit = (alu_free_o != '0);
        UNIT_MEM: fit = (mem_free_o != '0);
        default:  fit = (br_free_o  != '0);
      endcase
      if (!stop && rdy_i[p] && fit) begin
        grant_o[p] = 1'b1;
        pop_o      = pop_o + CW'(1);
        case (unit)
          UNIT_ALU: alu_free_o = alu_free_o - FW'(1);
          UNIT_MEM: mem_free_o = mem_free_o - FW'(1);
          default:  br_free_o  = br_free_o  - FW'(1);
        endcase
      end else begin
        stop = 1'b1;
      end
    end
  end

endmodule

// File: rtl/slot_map.sv
module slot_map
  import smt_issue_pkg::*;
#(
  parameter int NUM_THREADS = 3,
  parameter int SCAN_DEPTH  = 4,
  parameter int NUM_ALU     = 2,
  parameter int NUM_MEM     = 1,
  parameter int NUM_BR      = 1,
  parameter int TW          = 2,
  parameter int PW          = 2,
  localparam int NS         = NUM_ALU + NUM_MEM + NUM_BR
) (
  input  logic [NUM_THREADS*SCAN_DEPTH-1:0]   grant_i,
  input  logic [NUM_THREADS*SCAN_DEPTH*2-1:0] cls_i,
  output logic [NS-1:0]                       slot_vld_o,
  output logic [NS*TW-1:0]                    slot_tid_o,
  output logic [NS*PW-1:0]                    slot_pos_o
);

  int alu_used, mem_used, br_used, idx;

  // grants are visited in priority order: thread first, then queue position
  always_comb begin
    slot_vld_o = '0;
    slot_tid_o = '0;
    slot_pos_o = '0;
    alu_used   = 0;
    mem_used   = 0;
    br_used    = 0;
    idx        = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int p = 0; p < SCAN_DEPTH; p++) begin
        if (grant_i[t*SCAN_DEPTH+p]) begin
          case (unit_of(cls_i[(t*SCAN_DEPTH+p)*2 +: 2]))
            UNIT_ALU: begin idx = alu_used;                     alu_used++; end
            UNIT_MEM: begin idx = NUM_ALU + mem_used;           mem_used++; end
            default:  begin idx = NUM_ALU + NUM_MEM + br_used;  br_used++;  end
          endcase
          if (idx < NS) begin
            slot_vld_o[idx]            = 1'b1;
            slot_tid_o[idx*TW +: TW]   = TW'(t);
            slot_pos_o[idx*PW +: PW]   = PW'(p);
          end
        end
      end
    end
  end

endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc
  import smt_issue_pkg::*;
#(
  parameter int NUM_THREADS = 3,
  parameter int SCAN_DEPTH  = 4,
  parameter int NUM_ALU     = 2,
  parameter int NUM_MEM     = 1,
  parameter int NUM_BR      = 1,
  localparam int NS         = NUM_ALU + NUM_MEM + NUM_BR,
  localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int PW         = (SCAN_DEPTH > 1) ? $clog2(SCAN_DEPTH) : 1,
  localparam int CW         = $clog2(SCAN_DEPTH + 1),
  localparam int NE         = NUM_THREADS * SCAN_DEPTH
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NE*2-1:0]            cls_i,
  input  logic [NE-1:0]              rdy_i,
  output logic [NS-1:0]              slot_vld_o,
  output logic [NS*TW-1:0]           slot_tid_o,
  output logic [NS*PW-1:0]           slot_pos_o,
  output logic [NUM_THREADS*CW-1:0]  pop_cnt_o
);

  localparam int MAXU = (NUM_ALU > NUM_MEM) ? ((NUM_ALU > NUM_BR) ? NUM_ALU : NUM_BR)
                                            : ((NUM_MEM > NUM_BR) ? NUM_MEM : NUM_BR);
  localparam int FW   = $clog2(MAXU + 1);

  logic [FW-1:0]             alu_chain [NUM_THREADS+1];
  logic [FW-1:0]             mem_chain [NUM_THREADS+1];
  logic [FW-1:0]             br_chain  [NUM_THREADS+1];
  logic [NE-1:0]             grant;
  logic [NUM_THREADS*CW-1:0] pop_d;
  logic [NS-1:0]             vld_d;
  logic [NS*TW-1:0]          tid_d;
  logic [NS*PW-1:0]          pos_d;

  assign alu_chain[0] = FW'(NUM_ALU);
  assign mem_chain[0] = FW'(NUM_MEM);
  assign br_chain[0]  = FW'(NUM_BR);

  // priority chain: each thread sees the slots left by higher-priority ones
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thread_scan #(
      .SCAN_DEPTH (SCAN_DEPTH),
      .FW         (FW),
      .CW         (CW)
    ) u_scan (
      .cls_i      (cls_i[t*SCAN_DEPTH*2 +: SCAN_DEPTH*2]),
      .rdy_i      (rdy_i[t*SCAN_DEPTH +: SCAN_DEPTH]),
      .alu_free_i (alu_chain[t]),
      .mem_free_i (mem_chain[t]),
      .br_free_i  (br_chain[t]),
      .alu_free_o (alu_chain[t+1]),
      .mem_free_o (mem_chain[t+1]),
      .br_free_o  (br_chain[t+1]),
      .grant_o    (grant[t*SCAN_DEPTH +: SCAN_DEPTH]),
      .pop_o      (pop_d[t*CW +: CW])
    );
  end

  slot_map #(
    .NUM_THREADS (NUM_THREADS),
    .SCAN_DEPTH  (SCAN_DEPTH),
    .NUM_ALU     (NUM_ALU),
    .NUM_MEM     (NUM_MEM),
    .NUM_BR      (NUM_BR),
    .TW          (TW),
    .PW          (PW)
  ) u_map (
    .grant_i    (grant),
    .cls_i      (cls_i),
    .slot_vld_o (vld_d),
    .slot_tid_o (tid_d),
    .slot_pos_o (pos_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld_o <= '0;
      slot_tid_o <= '0;
      slot_pos_o <= '0;
      pop_cnt_o  <= '0;
    end else begin
      slot_vld_o <= vld_d;
      slot_tid_o <= tid_d;
      slot_pos_o <= pos_d;
      pop_cnt_o  <= pop_d;
    end
  end

  // ---------------- assertions ----------------
  int pop_sum_q, pop_sum_d;
  always_comb begin
    pop_sum_q = 0;
    pop_sum_d = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      pop_sum_q += int'(pop_cnt_o[t*CW +: CW]);
      pop_sum_d += int'(pop_d[t*CW +: CW]);
    end
  end

  function automatic logic [1:0] cls_at(input logic [NE*2-1:0] v,
                                        input logic [TW-1:0] t,
                                        input logic [PW-1:0] p);
    return v[(int'(t)*SCAN_DEPTH + int'(p))*2 +: 2];
  endfunction

  function automatic unit_e slot_unit(input int k);
    if (k < NUM_ALU)                return UNIT_ALU;
    else if (k < NUM_ALU + NUM_MEM) return UNIT_MEM;
    else                            return UNIT_BR;
  endfunction

  assert_pop_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_sum_q == $countones(slot_vld_o));

  assert_free_acct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_sum_d + int'(alu_chain[NUM_THREADS]) + int'(mem_chain[NUM_THREADS])
      + int'(br_chain[NUM_THREADS]) == NS);

  for (genvar k = 0; k < NS; k++) begin : g_slot_chk
    assert_slot_type_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[k] |->
        unit_of(cls_at($past(cls_i), slot_tid_o[k*TW +: TW], slot_pos_o[k*PW +: PW]))
          == slot_unit(k));
  end

  for (genvar k = 1; k < NUM_ALU; k++) begin : g_alu_chk
    assert_alu_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[k] |-> slot_vld_o[k-1]);
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_head_chk
    assert_head_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_cnt_o[t*CW +: CW] != '0) |-> $past(rdy_i[t*SCAN_DEPTH]));
  end

endmodule

// File: tb/smt_issue_alloc_tb.sv
module smt_issue_alloc_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A = 2'b00, L = 2'b01, S = 2'b10, B = 2'b11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] cls = '0;
  logic [11:0] rdy = '0;
  logic [3:0]  slot_vld;
  logic [7:0]  slot_tid;
  logic [7:0]  slot_pos;
  logic [8:0]  pop_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_issue_alloc u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cls_i      (cls),
    .rdy_i      (rdy),
    .slot_vld_o (slot_vld),
    .slot_tid_o (slot_tid),
    .slot_pos_o (slot_pos),
    .pop_cnt_o  (pop_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_slot(input string req, input int k, input bit v, input int t, input int p);
    chk(req, $sformatf("slot%0d vld", k), int'(slot_vld[k]), int'(v));
    if (v) begin
      chk(req, $sformatf("slot%0d tid", k), int'(slot_tid[k*2 +: 2]), t);
      chk(req, $sformatf("slot%0d pos", k), int'(slot_pos[k*2 +: 2]), p);
    end
  endtask

  task automatic chk_pops(input string req, input int p0, input int p1, input int p2);
    chk(req, "pop t0", int'(pop_cnt[0 +: 3]), p0);
    chk(req, "pop t1", int'(pop_cnt[3 +: 3]), p1);
    chk(req, "pop t2", int'(pop_cnt[6 +: 3]), p2);
  endtask

  task automatic set_thr(input int t, input logic [1:0] c0, c1, c2, c3, input logic [3:0] r);
    cls[(t*4+0)*2 +: 2] = c0;
    cls[(t*4+1)*2 +: 2] = c1;
    cls[(t*4+2)*2 +: 2] = c2;
    cls[(t*4+3)*2 +: 2] = c3;
    rdy[t*4 +: 4]       = r;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    set_thr(0, A, A, A, A, 4'hF);
    repeat (3) @(posedge clk);
    #1;
    chk_slot("R1", 0, 0, 0, 0);
    chk_slot("R1", 3, 0, 0, 0);
    chk_pops("R1", 0, 0, 0);
    cls = '0; rdy = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    chk("R1", "vld after reset", int'(slot_vld), 0);
    chk_pops("R1", 0, 0, 0);
  endtask

  task automatic t_alu_flood();
    set_thr(0, A, A, A, A, 4'hF);
    set_thr(1, A, A, A, A, 4'hF);
    set_thr(2, A, A, A, A, 4'hF);
    step();
    chk_slot("R9", 0, 1, 0, 0);
    chk_slot("R9", 1, 1, 0, 1);
    chk_slot("R5", 2, 0, 0, 0);
    chk_slot("R5", 3, 0, 0, 0);
    chk_pops("R3", 2, 0, 0);
  endtask

  task automatic t_full_thread();
    set_thr(0, A, L, B, A, 4'hF);
    set_thr(1, A, S, B, A, 4'hF);
    set_thr(2, B, A, A, A, 4'hF);
    step();
    chk_slot("R8", 0, 1, 0, 0);
    chk_slot("R8", 1, 1, 0, 3);
    chk_slot("R2", 2, 1, 0, 1);
    chk_slot("R2", 3, 1, 0, 2);
    chk_pops("R8", 4, 0, 0);
  endtask

  task automatic t_not_ready();
    set_thr(0, A, A, A, A, 4'b1101);
    set_thr(1, S, A, B, A, 4'hF);
    set_thr(2, A, A, A, A, 4'hF);
    step();
    chk_slot("R4", 0, 1, 0, 0);
    chk_slot("R3", 1, 1, 1, 1);
    chk_slot("R3", 2, 1, 1, 0);
    chk_slot("R3", 3, 1, 1, 2);
    chk_pops("R4", 1, 3, 0);
  endtask

  task automatic t_mem_share();
    set_thr(0, L, S, A, A, 4'hF);
    set_thr(1, A, B, A, L, 4'hF);
    set_thr(2, S, A, A, A, 4'hF);
    step();
    chk_slot("R6", 2, 1, 0, 0);
    chk_slot("R6", 0, 1, 1, 0);
    chk_slot("R6", 1, 1, 1, 2);
    chk_slot("R6", 3, 1, 1, 1);
    chk_pops("R6", 1, 3, 0);
  endtask

  task automatic t_leftover();
    set_thr(0, A, A, A, A, 4'b1110);
    set_thr(1, B, B, A, A, 4'hF);
    set_thr(2, A, A, L, A, 4'hF);
    step();
    chk_slot("R3", 3, 1, 1, 0);
    chk_slot("R3", 0, 1, 2, 0);
    chk_slot("R3", 1, 1, 2, 1);
    chk_slot("R3", 2, 1, 2, 2);
    chk_pops("R5", 0, 1, 3);
  endtask

  task automatic t_latency();
    rdy = '0;
    #2;
    chk("R10", "pop t2 held", int'(pop_cnt[6 +: 3]), 3);
    chk("R10", "vld held", int'(slot_vld), 4'hF);
    step();
    chk("R10", "vld after edge", int'(slot_vld), 0);
    chk_pops("R10", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu_flood();
    t_full_thread();
    t_not_ready();
    t_mem_share();
    t_leftover();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule